// File: doc/BRIEF.md
# Memory-Mapped PHY Management Bridge

This block lets a processor reach the 32 management registers of external Ethernet PHYs through plain bus loads and stores. Each of two windows covers 32 word locations, and word k of a window is PHY register k. The block turns one bus access into one complete clause-22 management frame on the serial MDC/MDIO pair. The shift-out, the turnaround and the capture of read data are all done in hardware, so software does no bit-level work.

Each window has its own 5-bit PHY-address register, held in a small configuration area above the windows. Software sets it once, and every access through that window then targets that PHY. The bus side is a request/wait interface. A master raises `bus_req` with address, direction and write data, and holds them. The access completes in the first cycle in which `bus_wait` is low while `bus_req` is high. Read data is valid in that cycle.

Word address layout, with `bus_addr` 7 bits wide at the default of two windows:
- bit 6 clear: window access. Bit 5 picks the window and bits 4:0 give the PHY register.
- bit 6 set: configuration access. Bit 0 picks the window whose PHY-address register is accessed.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After reset, `mdc` is low, `mdio_oe` is low, `bus_wait` is low while `bus_req` is low, and both PHY-address registers read back as 0.
- R2: A configuration access (address bit 6 set, bit 0 = window w) reaches the PHY-address register of window w. A write stores `bus_wdata[4:0]` and ignores the higher bits. A read returns the value in bits 4:0 with zeros above. `bus_wait` is high for exactly one sampled cycle.
- R3: A window write (address bit 6 clear, bit 5 = window, bits 4:0 = register) sends one frame, MSB first: 32 ones, start 01, opcode 01, the window's 5-bit PHY address, the 5-bit register index, turnaround 10, then `bus_wdata[15:0]`. Register indices 0 and 31 are both reachable.
- R4: A window read sends the same header with opcode 10. It releases MDIO (`mdio_oe` low) for the 18 bit times of turnaround and data. It returns `{16'b0, d}` on `bus_rdata`, where d is the 16 bits sampled on the data-phase rising MDC edges, with the first sample as bit 15.
- R5: `mdc` stays low while no frame is active. During a frame it toggles every `MDC_HALF` clock cycles and gives exactly 64 rising edges per frame. `mdio_o` and `mdio_oe` never change on the clock edge at which `mdc` rises.
- R6: For a window access, `bus_wait` is high for 128*`MDC_HALF`+1 sampled cycles, counted from the first cycle the request is presented. It drops in the cycle after the final falling MDC edge.
- R7: Each window uses its own PHY-address register. Writing one register leaves the other window's frames and read-back unchanged.
- R8: If `bus_req` stays high after an access completes, the new request is held off until that completion has been taken. It then becomes exactly one new complete access: none is dropped and none is run twice.
- R9: Bits 31:16 of the write data never appear on the MDIO line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until completion |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (7) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wait | output | 1 | Holds the bus while an access is in progress |
| bus_rdata | output | DATA_W (32) | Read data, valid in the completion cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable of the pad |
| mdio_i | input | 1 | MDIO line value seen at the pad |

## Verification
A configuration access is due one cycle after the request, so exactly one sampled cycle shows `bus_wait` high. A window access is due 128*`MDC_HALF`+1 cycles after the request (513 at the default). The bench drives each request on a falling clock edge and samples `bus_wait` 1 ns later on every falling edge, so the wait count and `bus_rdata` are read in the completion cycle itself. Frame content is compared when the 64th rising MDC edge of the frame arrives. The MDC half period is measured between the rise and the fall of one bit, away from any other activity.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int PHY_AW     = 5;   // PHY address field width
  localparam int REG_AW     = 5;   // register index field width
  localparam int MII_DW     = 16;  // management data width
  localparam int PRE_BITS   = 32;  // preamble length
  localparam int FRAME_BITS = PRE_BITS + 4 + PHY_AW + REG_AW + 2 + MII_DW;
  localparam int TA_IDX     = PRE_BITS + 4 + PHY_AW + REG_AW;  // first turnaround bit
  localparam int DATA_IDX   = TA_IDX + 2;                      // first data bit

  // Transmit order is MSB first: bit FRAME_BITS-1 leaves the block first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              is_rd,
    input logic [PHY_AW-1:0] phy,
    input logic [REG_AW-1:0] regi,
    input logic [MII_DW-1:0] data
  );
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [MII_DW-1:0] pay;
    op  = is_rd ? 2'b10 : 2'b01;
    ta  = is_rd ? 2'b11 : 2'b10;
    pay = is_rd ? '1 : data;
    return {{PRE_BITS{1'b1}}, 2'b01, op, phy, regi, ta, pay};
  endfunction

endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
  parameter int HALF_PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == CW'(HALF_PERIOD - 1));
  assign rise_stb = run & wrap & ~mdc;
  assign fall_stb = run & wrap & mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/phy_addr_bank.sv
module phy_addr_bank #(
  parameter int N_WIN = 2,
  parameter int AW    = 5,
  localparam int SW   = $clog2(N_WIN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_idx,
  input  logic [AW-1:0] wr_val,
  input  logic [SW-1:0] frame_idx,
  output logic [AW-1:0] frame_phy,
  input  logic [SW-1:0] cfg_idx,
  output logic [AW-1:0] cfg_phy
);
  logic [AW-1:0] slot [N_WIN];

  for (genvar g = 0; g < N_WIN; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[g] <= '0;
      else if (wr_en && (wr_idx == SW'(g)))
        slot[g] <= wr_val;
    end
  end

  assign frame_phy = slot[frame_idx];
  assign cfg_phy   = slot[cfg_idx];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import phy_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  is_read,
  input  logic                  rise_stb,
  input  logic                  fall_stb,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  done,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [MII_DW-1:0]     rd_data
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh;
  logic [CNT_W-1:0]      idx;
  logic [CNT_W-1:0]      idx_nx;
  logic                  rd_q;

  assign idx_nx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
      sh      <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          sh      <= frame;
          idx     <= '0;
          rd_q    <= is_read;
          mdio_o  <= frame[FRAME_BITS-1];
          mdio_oe <= 1'b1;
        end
      end else begin
        // capture on the rising edge, during the data phase of a read
        if (rise_stb && rd_q && (idx >= CNT_W'(DATA_IDX)))
          rd_data <= {rd_data[MII_DW-2:0], mdio_i};
        // advance on the falling edge
        if (fall_stb) begin
          if (idx == CNT_W'(FRAME_BITS - 1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            idx     <= idx_nx;
            sh      <= sh << 1;
            mdio_o  <= sh[FRAME_BITS-2];
            mdio_oe <= !(rd_q && (idx_nx >= CNT_W'(TA_IDX)));
          end
        end
      end
    end
  end
endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge
  import phy_mgmt_pkg::*;
#(
  parameter int N_WIN    = 2,
  parameter int MDC_HALF = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(N_WIN) + REG_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wait,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int WSEL_W = $clog2(N_WIN);

  logic              cfg_hit;
  logic [WSEL_W-1:0] win_sel;
  logic [WSEL_W-1:0] cfg_sel;
  logic [REG_AW-1:0] reg_sel;
  logic              accept;
  logic              cfg_go;
  logic              win_go;
  logic              ack;
  logic              cfg_ack_q;
  logic              rd_sel_eng_q;
  logic [DATA_W-1:0] cfg_rdata_q;
  logic [PHY_AW-1:0] frame_phy;
  logic [PHY_AW-1:0] cfg_phy;
  logic              eng_busy;
  logic              eng_done;
  logic [MII_DW-1:0] eng_rdata;
  logic              rise_stb;
  logic              fall_stb;
  logic [FRAME_BITS-1:0] frame;
  logic              unused_ok;

  // address split
  assign cfg_hit = bus_addr[ADDR_W-1];
  assign win_sel = bus_addr[REG_AW +: WSEL_W];
  assign cfg_sel = bus_addr[WSEL_W-1:0];
  assign reg_sel = bus_addr[REG_AW-1:0];

  // request acceptance: never while a frame runs or a completion is shown
  assign ack      = eng_done | cfg_ack_q;
  assign bus_wait = bus_req & ~ack;
  assign accept   = bus_req & ~eng_busy & ~ack;
  assign cfg_go   = accept & cfg_hit;
  assign win_go   = accept & ~cfg_hit;

  assign unused_ok = &{1'b0, bus_wdata[DATA_W-1:MII_DW]};

  phy_addr_bank #(.N_WIN(N_WIN), .AW(PHY_AW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_go & bus_write),
    .wr_idx    (cfg_sel),
    .wr_val    (bus_wdata[PHY_AW-1:0]),
    .frame_idx (win_sel),
    .frame_phy (frame_phy),
    .cfg_idx   (cfg_sel),
    .cfg_phy   (cfg_phy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ack_q    <= 1'b0;
      cfg_rdata_q  <= '0;
      rd_sel_eng_q <= 1'b0;
    end else begin
      cfg_ack_q <= cfg_go;
      if (cfg_go) begin
        cfg_rdata_q  <= DATA_W'(cfg_phy);
        rd_sel_eng_q <= 1'b0;
      end else if (win_go) begin
        rd_sel_eng_q <= 1'b1;
      end
    end
  end

  assign frame = build_frame(~bus_write, frame_phy, reg_sel, bus_wdata[MII_DW-1:0]);

  mdc_clock_gen #(.HALF_PERIOD(MDC_HALF)) u_mdc (
    .clk      (clk),
    .rst      (rst),
    .run      (eng_busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (win_go),
    .frame    (frame),
    .is_read  (~bus_write),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .done     (eng_done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (eng_rdata)
  );

  assign bus_rdata = rd_sel_eng_q ? DATA_W'(eng_rdata) : cfg_rdata_q;
endmodule

// File: rtl/phy_mgmt_bridge_chk.sv
module phy_mgmt_bridge_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic bus_wait,
  input logic eng_busy
);
  // R5: the management clock rests low outside a frame
  p_mdc_low_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> !mdc);

  // R5: the driven MDIO value and enable hold still across a rising MDC edge
  p_stable_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R4: the pad is driven only while a frame is in flight
  p_oe_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> eng_busy);

  // R6: the bus is released in the cycle the frame ends
  p_release_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_busy) |-> !bus_wait);
endmodule

bind phy_mgmt_bridge phy_mgmt_bridge_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .bus_wait (bus_wait),
  .eng_busy (eng_busy)
);

// File: tb/phy_mgmt_bridge_bench.sv
module phy_mgmt_bridge_bench;
  localparam int HALF   = 4;
  localparam int ADDR_W = 7;
  localparam int WIN_WAIT = 128 * HALF + 1;

  typedef struct {
    bit        rd;
    bit [4:0]  phy;
    bit [4:0]  rg;
    bit [15:0] data;
  } frm_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wait;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, line;
  logic        phy_o = 1'b1;
  logic        phy_oe = 1'b0;

  int vec = 0;
  int errs = 0;
  frm_t exp_q[$];
  logic [15:0] phy_mem [32][32];
  bit [4:0] pa_model [2];

  // monitor state
  int          bitn = 0;
  int          oe_low = 0;
  logic [63:0] cap = '0;
  bit          cur_rd = 0;
  bit [4:0]    cur_phy = 0;
  bit [4:0]    cur_rg = 0;
  realtime     t_rise = 0;

  always #2 clk = ~clk;   // 250 MHz

  assign line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  phy_mgmt_bridge u_phy_mgmt_bridge (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wait(bus_wait),
    .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(line)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- PHY model and scoreboard monitor ----------------
  task automatic end_frame();
    frm_t e;
    if (exp_q.size() == 0) begin
      chk("R8 unexpected frame", 32'd1, 32'd0);
      return;
    end
    e = exp_q.pop_front();
    chk("R3 preamble", cap[63:32], 32'hFFFF_FFFF);
    chk("R3 start code", 32'(cap[31:30]), 32'h1);
    chk(e.rd ? "R4 opcode" : "R3 opcode", 32'(cap[29:28]), e.rd ? 32'h2 : 32'h1);
    chk("R7 phy address", 32'(cap[27:23]), 32'(e.phy));
    chk("R3 register index", 32'(cap[22:18]), 32'(e.rg));
    chk("R3 turnaround", 32'(cap[17:16]), 32'h2);
    chk(e.rd ? "R4 line data" : "R9 write data", 32'(cap[15:0]), 32'(e.data));
    chk("R4 released bit times", oe_low, e.rd ? 18 : 0);
    if (!e.rd) phy_mem[cap[27:23]][cap[22:18]] = cap[15:0];
  endtask

  always @(posedge mdc) begin
    cap = {cap[62:0], line};
    if (!mdio_oe) oe_low++;
    if (bitn == 10) t_rise = $realtime;
    bitn++;
    if (bitn == 46) begin
      cur_rd  = (cap[11:10] == 2'b10);
      cur_phy = cap[9:5];
      cur_rg  = cap[4:0];
    end
    if (bitn == 64) begin
      end_frame();   // R5: 64 rising edges make one frame
      bitn = 0;
      oe_low = 0;
    end
  end

  always @(negedge mdc) begin
    if (bitn == 11)
      chk("R5 mdc half period ns", 32'($rtoi($realtime - t_rise)), 32'(HALF * 4));
    #1;
    phy_oe = 1'b0;
    phy_o  = 1'b1;
    if (cur_rd && bitn == 47) begin
      phy_oe = 1'b1;
      phy_o  = 1'b0;
    end else if (cur_rd && bitn >= 48 && bitn <= 63) begin
      phy_oe = 1'b1;
      phy_o  = phy_mem[cur_phy][cur_rg][63 - bitn];
    end
  end

  // ---------------- driver ----------------
  // Called at a falling clock edge; returns at a falling clock edge.
  task automatic bus_access(input bit wr, input logic [ADDR_W-1:0] a,
                            input logic [31:0] wd, input bit hold,
                            output logic [31:0] rd, output int wc);
    bus_req = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = wd;
    wc = 0;
    #1;
    while (bus_wait === 1'b1) begin
      wc++;
      @(negedge clk); #1;
    end
    rd = bus_rdata;
    @(negedge clk);
    if (!hold) bus_req = 1'b0;
  endtask

  task automatic cfg_access(input bit wr, input bit w, input logic [31:0] wd,
                            output logic [31:0] rd);
    int wc;
    bus_access(wr, {1'b1, 5'd0, w}, wd, 1'b0, rd, wc);
    chk("R2 config wait cycles", wc, 1);
    if (wr) pa_model[w] = wd[4:0];
  endtask

  task automatic win_access(input bit wr, input bit w, input logic [4:0] rg,
                            input logic [31:0] wd, input bit hold, input string tag);
    frm_t e;
    logic [31:0] rd;
    int wc;
    e.rd = !wr; e.phy = pa_model[w]; e.rg = rg;
    e.data = wr ? wd[15:0] : phy_mem[pa_model[w]][rg];
    exp_q.push_back(e);
    bus_access(wr, {1'b0, w, rg}, wd, hold, rd, wc);
    chk({tag, " / R6 window wait cycles"}, wc, WIN_WAIT);
    if (!wr) chk({tag, " / R4 read data"}, rd, {16'h0, e.data});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL R6 watchdog actual=hung expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] r;
    for (int p = 0; p < 32; p++)
      for (int q = 0; q < 32; q++)
        phy_mem[p][q] = 16'hA000 ^ 16'(p << 8) ^ 16'(q * 16'h0111);
    pa_model[0] = 0; pa_model[1] = 0;

    repeat (5) @(negedge clk);
    chk("R1 mdc low in reset", 32'(mdc), 0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk("R1 mdc idle", 32'(mdc), 0);
    chk("R1 mdio_oe idle", 32'(mdio_oe), 0);
    chk("R1 bus_wait idle", 32'(bus_wait), 0);
    @(negedge clk);

    cfg_access(0, 0, 0, r); chk("R1 phy addr A reset", r, 0);
    cfg_access(0, 1, 0, r); chk("R1 phy addr B reset", r, 0);

    cfg_access(1, 0, 32'h0000_0005, r);
    cfg_access(1, 1, 32'hFFFF_FFFA, r);
    cfg_access(0, 0, 0, r); chk("R2 phy addr A readback", r, 32'h5);
    cfg_access(0, 1, 0, r); chk("R2 phy addr B upper bits dropped", r, 32'h1A);

    win_access(1, 0, 5'd7, 32'hDEAD_1234, 0, "R3 R9 write A reg7");
    win_access(0, 0, 5'd7, 0, 0, "R4 read A reg7");
    win_access(0, 1, 5'd0, 0, 0, "R7 read B reg0");
    win_access(1, 1, 5'd31, 32'h1234_BEEF, 0, "R3 write B reg31");
    win_access(0, 1, 5'd31, 0, 0, "R4 read B reg31");
    win_access(0, 0, 5'd31, 0, 0, "R7 read A reg31 untouched");

    cfg_access(1, 0, 32'h0000_001F, r);
    cfg_access(0, 1, 0, r); chk("R7 phy addr B unchanged", r, 32'h1A);
    win_access(0, 0, 5'd0, 0, 0, "R3 read phy31 reg0");

    // back-to-back with the request left high
    win_access(1, 0, 5'd3, 32'hFFFF_5555, 1, "R8 first of pair");
    win_access(0, 0, 5'd3, 0, 0, "R8 second of pair");

    repeat (4) @(negedge clk);
    #1;
    chk("R8 all frames seen", exp_q.size(), 0);
    chk("R5 mdc idle after frames", 32'(mdc), 0);
    chk("R1 mdio_oe idle after frames", 32'(mdio_oe), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule